// File: doc/BRIEF.md
# Clock and Setup-RAM Access Steering

This block sits between a host I/O bus and two devices that share one data port: a real-time-clock chip reached through a multiplexed address/data bus, and a 2 KB battery-backed setup RAM. The host first writes an index value to the index port (low address byte 70h), then reads or writes the data port (low address byte 71h). A select bit of the stored index decides which device the data-port access reaches.

For the RAM, the low six address bits come from the stored index. The five high address bits come from I/O address lines 14:10 of the data-port access itself, so 0071h, 0471h and on up to 7C71h each reach a different 64-byte RAM page. For the clock, the block runs a two-phase strobe sequence. An address phase puts the index on the device bus. A data phase then performs the read or write. The host sees `io_busy` high while any data-port access is in progress, and read data is held on `io_rdata` until the next read completes.

Top module: `rtcram_steer`

## Requirements
- R1: After reset the index is 00h, so the clock is the target. `io_busy`, `rtc_cs`, `rtc_as`, `rtc_ds`, `rtc_ad_oe`, `ram_ce` and `ram_we` are all low, and `io_rdata` is 00h.
- R2: A write whose low address byte is 70h stores `io_wdata` in the index register, whatever the upper address byte. A write to any other low byte except 71h leaves the index unchanged. Bit 7 of the index has no effect on target selection.
- R3: The data port is decoded from the low address byte 71h alone. Address bits 15:8 do not take part in the decode.
- R4: When index bit 6 is 1, a data-port access drives `ram_ce` high for exactly one cycle, starting the cycle after the request. In that cycle `ram_addr` = {io_addr[14:10], index[5:0]}, `ram_we` equals the write flag and `ram_wdata` carries the written byte. `io_busy` is high for that one cycle.
- R5: A RAM read places the RAM byte on `io_rdata` in the cycle after `ram_ce` falls, and holds it there until the next read completes.
- R6: When index bit 6 is 0, a data-port access starts with an address phase of AS_CYCLES cycles, beginning the cycle after the request. During this phase `rtc_cs`, `rtc_as` and `rtc_ad_oe` are high, `rtc_ds` is low and `rtc_ad_out` = {2'b00, index[5:0]}.
- R7: The address phase is followed by a data phase of DS_CYCLES cycles. During this phase `rtc_cs` and `rtc_ds` are high, `rtc_as` is low and `rtc_rw` is 1 for a read and 0 for a write. On a write, `rtc_ad_oe` is high and `rtc_ad_out` carries the written byte. On a read, `rtc_ad_oe` is low.
- R8: A clock read samples `rtc_ad_in` on the last data-phase cycle. The sampled byte appears on `io_rdata` in the cycle after `rtc_cs` falls.
- R9: Any host request made while `io_busy` is high is ignored. This includes index writes.
- R10: The two targets are never active together: `ram_ce` stays low during a clock access and `rtc_cs` stays low during a RAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write request, one cycle |
| io_rd | input | 1 | Host read request, one cycle |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Last read result |
| io_busy | output | 1 | Data-port access in progress |
| rtc_cs | output | 1 | Clock chip select |
| rtc_as | output | 1 | Clock address strobe |
| rtc_ds | output | 1 | Clock data strobe |
| rtc_rw | output | 1 | Clock direction, 1 = read |
| rtc_ad_out | output | 8 | Clock bus value driven by the block |
| rtc_ad_oe | output | 1 | Clock bus drive enable |
| rtc_ad_in | input | 8 | Clock bus value from the device |
| ram_addr | output | 11 | Setup RAM address |
| ram_ce | output | 1 | Setup RAM chip enable |
| ram_we | output | 1 | Setup RAM write enable |
| ram_wdata | output | 8 | Setup RAM write data |
| ram_rdata | input | 8 | Setup RAM read data |

## Verification
The bench builds the block with AS_CYCLES = 2 and DS_CYCLES = 3 instead of the defaults 1 and 2. With these values every phase lasts more than one cycle, so a strobe held one cycle too long or cut one cycle short shows up in the per-cycle comparison, and the capture point of a clock read can be told apart from its neighbours. The RAM geometry keeps its default, so all five page bits, up to address 7C71h, are exercised against the full 2 KB model.

// File: rtl/rtcram_pkg.sv
package rtcram_pkg;
   typedef enum logic [1:0] {
      PH_IDLE,
      PH_ADDR,
      PH_DATA
   } rtc_phase_e;
endpackage

// File: rtl/rtcram_index_reg.sv
module rtcram_index_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end

   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/rtcram_ram_port.sv
module rtcram_ram_port #(
   parameter int AW   = 11,
   parameter int LOW  = 6,
   parameter int DW   = 8,
   localparam int HIW = AW - LOW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           is_wr,
   input  logic [HIW-1:0] page,
   input  logic [LOW-1:0] offset,
   input  logic [DW-1:0]  wdata,
   output logic [AW-1:0]  ram_addr,
   output logic           ram_ce,
   output logic           ram_we,
   output logic [DW-1:0]  ram_wdata,
   output logic           rd_take
);
   logic [AW-1:0] addr_q;
   logic          ce_q, we_q;
   logic [DW-1:0] wd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         ce_q   <= 1'b0;
         we_q   <= 1'b0;
         wd_q   <= '0;
      end else if (start) begin
         addr_q <= {page, offset};
         ce_q   <= 1'b1;
         we_q   <= is_wr;
         wd_q   <= wdata;
      end else begin
         ce_q   <= 1'b0;
         we_q   <= 1'b0;
      end
   end

   assign ram_addr  = addr_q;
   assign ram_ce    = ce_q;
   assign ram_we    = we_q;
   assign ram_wdata = wd_q;
   assign rd_take   = ce_q & ~we_q;

   a_r4_single_cycle_ce: assert property (@(posedge clk) disable iff (!rst_n)
      ram_ce |=> !ram_ce);
   a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ram_ce);
endmodule

// File: rtl/rtcram_rtc_seq.sv
module rtcram_rtc_seq
   import rtcram_pkg::*;
#(
   parameter int AS_CYCLES = 1,
   parameter int DS_CYCLES = 2,
   parameter int RAW       = 6,
   parameter int DW        = 8,
   localparam int MAXC     = (AS_CYCLES > DS_CYCLES) ? AS_CYCLES : DS_CYCLES,
   localparam int CW       = $clog2(MAXC + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           is_wr,
   input  logic [RAW-1:0] reg_addr,
   input  logic [DW-1:0]  wdata,
   output logic           rtc_cs,
   output logic           rtc_as,
   output logic           rtc_ds,
   output logic           rtc_rw,
   output logic [DW-1:0]  rtc_ad_out,
   output logic           rtc_ad_oe,
   output logic           rd_take
);
   rtc_phase_e     ph_q;
   logic [CW-1:0]  cnt_q;
   logic           wr_q;
   logic [RAW-1:0] ra_q;
   logic [DW-1:0]  wd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         wr_q  <= 1'b0;
         ra_q  <= '0;
         wd_q  <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (start) begin
               ph_q  <= PH_ADDR;
               cnt_q <= CW'(AS_CYCLES - 1);
               wr_q  <= is_wr;
               ra_q  <= reg_addr;
               wd_q  <= wdata;
            end
            PH_ADDR: if (cnt_q == '0) begin
               ph_q  <= PH_DATA;
               cnt_q <= CW'(DS_CYCLES - 1);
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            PH_DATA: if (cnt_q == '0) ph_q <= PH_IDLE;
                     else             cnt_q <= cnt_q - 1'b1;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign rtc_cs     = (ph_q != PH_IDLE);
   assign rtc_as     = (ph_q == PH_ADDR);
   assign rtc_ds     = (ph_q == PH_DATA);
   assign rtc_rw     = (ph_q == PH_IDLE) ? 1'b1 : ~wr_q;
   assign rtc_ad_oe  = rtc_as | (rtc_ds & wr_q);
   assign rtc_ad_out = rtc_as ? {{(DW-RAW){1'b0}}, ra_q} : wd_q;
   assign rd_take    = rtc_ds & ~wr_q & (cnt_q == '0);

   a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rtc_as && rtc_ds));
   a_r6_strobe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (rtc_as || rtc_ds) |-> rtc_cs);
   a_r6_addr_driven: assert property (@(posedge clk) disable iff (!rst_n)
      rtc_as |-> rtc_ad_oe);
   a_r7_dir_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (rtc_ds && $past(rtc_ds)) |-> $stable(rtc_rw));
endmodule

// File: rtl/rtcram_steer.sv
module rtcram_steer #(
   parameter int          DW        = 8,
   parameter int          AW_IO     = 16,
   parameter int          RAM_AW    = 11,
   parameter int          LOW_BITS  = 6,
   parameter int          PAGE_LSB  = 10,
   parameter int          SEL_BIT   = 6,
   parameter logic [7:0]  IDX_PORT  = 8'h70,
   parameter logic [7:0]  DATA_PORT = 8'h71,
   parameter int          AS_CYCLES = 1,
   parameter int          DS_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW_IO-1:0]  io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DW-1:0]     io_wdata,
   output logic [DW-1:0]     io_rdata,
   output logic              io_busy,
   output logic              rtc_cs,
   output logic              rtc_as,
   output logic              rtc_ds,
   output logic              rtc_rw,
   output logic [DW-1:0]     rtc_ad_out,
   output logic              rtc_ad_oe,
   input  logic [DW-1:0]     rtc_ad_in,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_ce,
   output logic              ram_we,
   output logic [DW-1:0]     ram_wdata,
   input  logic [DW-1:0]     ram_rdata
);
   localparam int HIW = RAM_AW - LOW_BITS;

   generate
      if (AS_CYCLES < 1 || DS_CYCLES < 1) begin : g_bad_phase
         $error("phase lengths must be at least one cycle");
      end
      if (PAGE_LSB + HIW > AW_IO) begin : g_bad_page
         $error("page bits exceed the I/O address width");
      end
      if (SEL_BIT < LOW_BITS || SEL_BIT >= DW) begin : g_bad_sel
         $error("select bit must lie above the offset field");
      end
      if (PAGE_LSB < 8) begin : g_bad_lsb
         $error("page bits must lie above the decoded address byte");
      end
   endgenerate

   logic [DW-1:0]  idx_q;
   logic [HIW-1:0] page;
   logic           hit_idx, hit_dat, req, idx_load;
   logic           go_ram, go_rtc;
   logic           ram_take, rtc_take;
   logic [DW-1:0]  rdata_q;
   logic           unused_bits;

   assign req      = io_wr | io_rd;
   assign hit_idx  = (io_addr[7:0] == IDX_PORT);
   assign hit_dat  = (io_addr[7:0] == DATA_PORT);
   assign idx_load = io_wr & hit_idx & ~io_busy;
   assign go_ram   = req & hit_dat & ~io_busy &  idx_q[SEL_BIT];
   assign go_rtc   = req & hit_dat & ~io_busy & ~idx_q[SEL_BIT];

   genvar gi;
   generate
      for (gi = 0; gi < HIW; gi++) begin : g_page
         assign page[gi] = io_addr[PAGE_LSB + gi];
      end
   endgenerate

   assign unused_bits = ^{io_addr, idx_q};

   rtcram_index_reg #(.W(DW)) u_idx (
      .clk (clk), .rst_n(rst_n), .load(idx_load), .din(io_wdata), .q(idx_q)
   );

   rtcram_ram_port #(.AW(RAM_AW), .LOW(LOW_BITS), .DW(DW)) u_ram (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (go_ram),
      .is_wr    (io_wr),
      .page     (page),
      .offset   (idx_q[LOW_BITS-1:0]),
      .wdata    (io_wdata),
      .ram_addr (ram_addr),
      .ram_ce   (ram_ce),
      .ram_we   (ram_we),
      .ram_wdata(ram_wdata),
      .rd_take  (ram_take)
   );

   rtcram_rtc_seq #(
      .AS_CYCLES(AS_CYCLES), .DS_CYCLES(DS_CYCLES), .RAW(LOW_BITS), .DW(DW)
   ) u_rtc (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (go_rtc),
      .is_wr     (io_wr),
      .reg_addr  (idx_q[LOW_BITS-1:0]),
      .wdata     (io_wdata),
      .rtc_cs    (rtc_cs),
      .rtc_as    (rtc_as),
      .rtc_ds    (rtc_ds),
      .rtc_rw    (rtc_rw),
      .rtc_ad_out(rtc_ad_out),
      .rtc_ad_oe (rtc_ad_oe),
      .rd_take   (rtc_take)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        rdata_q <= '0;
      else if (ram_take) rdata_q <= ram_rdata;
      else if (rtc_take) rdata_q <= rtc_ad_in;
   end

   assign io_rdata = rdata_q;
   assign io_busy  = ram_ce | rtc_cs;

   a_r10_targets_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rtc_cs && ram_ce));
   a_r9_index_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
      io_busy |=> $stable(idx_q));
   a_r5_rdata_held_unless_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_take && !rtc_take) |=> $stable(io_rdata));
endmodule

// File: tb/rtcram_steer_bench.sv
module rtcram_steer_bench;
   localparam int AS_C = 2;
   localparam int DS_C = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_busy;
   logic        rtc_cs, rtc_as, rtc_ds, rtc_rw, rtc_ad_oe;
   logic [7:0]  rtc_ad_out, rtc_ad_in;
   logic [10:0] ram_addr;
   logic        ram_ce, ram_we;
   logic [7:0]  ram_wdata, ram_rdata;

   always #4 clk = ~clk;

   rtcram_steer #(.AS_CYCLES(AS_C), .DS_CYCLES(DS_C)) u_rtcram_steer (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_busy(io_busy),
      .rtc_cs(rtc_cs), .rtc_as(rtc_as), .rtc_ds(rtc_ds), .rtc_rw(rtc_rw),
      .rtc_ad_out(rtc_ad_out), .rtc_ad_oe(rtc_ad_oe), .rtc_ad_in(rtc_ad_in),
      .ram_addr(ram_addr), .ram_ce(ram_ce), .ram_we(ram_we),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   // device models
   logic [7:0] rtc_mem [64];
   logic [7:0] ram_mem [2048];
   logic [5:0] rtc_lat = '0;
   assign rtc_ad_in = rtc_mem[rtc_lat];
   assign ram_rdata = ram_mem[ram_addr];
   always @(posedge clk) begin
      if (rtc_cs && rtc_as) rtc_lat <= rtc_ad_out[5:0];
      if (rtc_cs && rtc_ds && !rtc_rw) rtc_mem[rtc_lat] <= rtc_ad_out;
      if (ram_ce && ram_we) ram_mem[ram_addr] <= ram_wdata;
   end

   // expectation state
   logic [7:0] exp_rtc [64];
   logic [7:0] exp_ram [2048];
   logic [7:0] idx_m = '0;
   logic [7:0] rd_m = '0;
   int n_chk = 0, n_bad = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic [15:0] a, input bit wr, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = wr; io_rd = !wr;
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0;
   endtask

   task automatic set_index(input logic [15:0] a, input logic [7:0] d);
      pulse(a, 1'b1, d);
      if (a[7:0] == 8'h70) idx_m = d;
   endtask

   task automatic rtc_acc(input logic [15:0] a, input bit wr, input logic [7:0] d);
      logic [5:0] r;
      r = idx_m[5:0];
      pulse(a, wr, d);
      for (int k = 0; k < AS_C; k++) begin
         chk(rtc_cs && rtc_as && !rtc_ds && rtc_ad_oe && io_busy, "R6 addr phase strobes",
             {rtc_cs, rtc_as, rtc_ds, rtc_ad_oe}, 4'b1101);
         chk(rtc_ad_out == {2'b00, r}, "R6 index on bus", rtc_ad_out, r);
         chk(!ram_ce, "R10 ram idle in clock access", ram_ce, 0);
         @(negedge clk);
      end
      for (int k = 0; k < DS_C; k++) begin
         chk(rtc_cs && !rtc_as && rtc_ds && io_busy, "R7 data phase strobes",
             {rtc_cs, rtc_as, rtc_ds}, 3'b101);
         chk(rtc_rw == !wr && rtc_ad_oe == wr, "R7 direction", {rtc_rw, rtc_ad_oe}, {!wr, wr});
         if (wr) chk(rtc_ad_out == d, "R7 write data on bus", rtc_ad_out, d);
         chk(!ram_ce, "R10 ram idle in clock access", ram_ce, 0);
         @(negedge clk);
      end
      chk(!rtc_cs && !io_busy, "R7 sequence ends", {rtc_cs, io_busy}, 0);
      if (wr) exp_rtc[r] = d;
      else rd_m = exp_rtc[r];
      chk(io_rdata == rd_m, "R8 clock read result", io_rdata, rd_m);
   endtask

   task automatic ram_acc(input logic [15:0] a, input bit wr, input logic [7:0] d);
      logic [10:0] ea;
      ea = {a[14:10], idx_m[5:0]};
      pulse(a, wr, d);
      chk(ram_ce && io_busy && ram_we == wr, "R4 ram enable", {ram_ce, io_busy, ram_we}, {2'b11, wr});
      chk(ram_addr == ea, "R4 ram address", ram_addr, ea);
      if (wr) chk(ram_wdata == d, "R4 ram write data", ram_wdata, d);
      chk(!rtc_cs, "R10 clock idle in ram access", rtc_cs, 0);
      @(negedge clk);
      chk(!ram_ce && !io_busy, "R4 single cycle", {ram_ce, io_busy}, 0);
      if (wr) exp_ram[ea] = d;
      else rd_m = exp_ram[ea];
      chk(io_rdata == rd_m, "R5 ram read result", io_rdata, rd_m);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         rtc_mem[i] = 8'(i * 7 + 3); exp_rtc[i] = 8'(i * 7 + 3);
      end
      for (int i = 0; i < 2048; i++) begin
         ram_mem[i] = 8'(i ^ (i >> 3)); exp_ram[i] = 8'(i ^ (i >> 3));
      end
      repeat (3) @(negedge clk);
      chk(!io_busy && !rtc_cs && !rtc_as && !rtc_ds && !rtc_ad_oe && !ram_ce && !ram_we,
          "R1 idle outputs in reset", {io_busy, rtc_cs, ram_ce}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(io_rdata == 8'h00, "R1 read data after reset", io_rdata, 0);

      // R1: index 00h selects the clock
      rtc_acc(16'h0071, 1'b0, 8'h00);
      // clock write then read back
      set_index(16'h0070, 8'h0D);
      rtc_acc(16'h0071, 1'b1, 8'hA5);
      rtc_acc(16'h0071, 1'b0, 8'h00);
      // R3: upper address byte ignored for decode
      set_index(16'h0070, 8'h3F);
      rtc_acc(16'hFF71, 1'b0, 8'h00);
      // R2: index decoded on low byte only; bit 7 ignored for selection
      set_index(16'h5570, 8'hC2);
      ram_acc(16'h0071, 1'b1, 8'h5A);
      ram_acc(16'h0071, 1'b0, 8'h00);
      // R2: write to another port leaves index alone
      pulse(16'h0072, 1'b1, 8'h05);
      ram_acc(16'h0071, 1'b0, 8'h00);
      // R4: page bits from address 14:10, top page and middle page
      set_index(16'h0070, 8'h7F);
      ram_acc(16'h7C71, 1'b1, 8'h3C);
      ram_acc(16'h7C71, 1'b0, 8'h00);
      ram_acc(16'hA871, 1'b0, 8'h00);
      ram_acc(16'h0471, 1'b0, 8'h00);
      // R5: read data holds across a write
      ram_acc(16'h0871, 1'b1, 8'h11);
      @(negedge clk);
      chk(io_rdata == rd_m, "R5 read data held", io_rdata, rd_m);
      // R9: index write during a clock access is ignored
      set_index(16'h0070, 8'h21);
      pulse(16'h0071, 1'b0, 8'h00);
      io_addr = 16'h0070; io_wdata = 8'h40; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      for (int k = 0; k < 20 && io_busy; k++) @(negedge clk);
      chk(io_rdata == exp_rtc[6'h21], "R9 busy access completes", io_rdata, exp_rtc[6'h21]);
      rtc_acc(16'h0071, 1'b0, 8'h00);
      // R9: data request during a RAM access is ignored
      set_index(16'h0070, 8'h45);
      pulse(16'h0071, 1'b0, 8'h00);
      io_addr = 16'h0471; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      chk(!ram_ce && !io_busy, "R9 second request dropped", {ram_ce, io_busy}, 0);
      finish_run();
   end
endmodule